// File: doc/BRIEF.md
# Serial Response Frame Receiver

This block takes over a two-wire serial link right after a command frame has gone out and collects the slave's reply. It releases the data line, drives clock pulses, and samples one bit per pulse. Line data is active-low, so each sample is inverted. The receiver first looks for a start bit, and gives up after a bounded number of clock pulses. It then reads a 4-bit header, which holds the responding slave id and a 2-bit response tag. If the tag is an acknowledge and the request expects data, a data field of whole bytes follows. A 4-bit check code closes the frame.

Validation uses a zero residue. A 4-bit CRC is run from a zero start over every received bit, from the start bit up to and including the check bits. The result is zero for a good frame. The outcome appears on a one-cycle `done` strobe, together with the slave id, the tag, the right-aligned data and a status code. Command transmission and any retry or poll sequencing belong to neighbouring logic.

Top module: `resp_rx`

## Requirements
- R1: Out of reset and while idle, `sclk` is 1 and `busy`, `done` and `dat_release` are 0. A `start` pulse while idle begins a receive.
- R2: Each bit slot holds `sclk` low for one cycle and then high for one cycle. The first slot after `start` begins with the low cycle. The bit is sampled from `sdat_n` at the end of the high cycle and inverted, so a line level of 0 is a logical 1.
- R3: The start-bit hunt lasts at most TIMEOUT slots. A logical 1 found in slot TIMEOUT (the last one) is still accepted as the start bit.
- R4: If no start bit appears within TIMEOUT slots, the block reports status 1 (timeout), with `resp_id`, `resp_tag` and `rdata` all 0.
- R5: The 4 bits after the start bit form the header, received most significant bit first. Bits 3:2 are the slave id and bits 1:0 are the tag: 0 acknowledge, 1 busy, 2 general error, 3 slave saw a bad check code from the master.
- R6: A data field of 8 × `exp_bytes` bits is received only when the tag is 0 and `exp_bytes` is non-zero. Otherwise the check bits follow the header directly and `rdata` is 0.
- R7: Data bits arrive most significant first. The first byte received lands in the most significant byte of the right-aligned field in `rdata`.
- R8: The CRC uses the polynomial x^4+x+1 (feedback mask 0x3) and starts from zero. It is shifted over the start bit, header, data and the 4 check bits. A zero residue gives status 0. Any other residue gives status 2, and the id, tag and data are still reported.
- R9: `done` is a one-cycle pulse in the cycle after the last bit is sampled. `busy` is 0 in that cycle.
- R10: A `start` pulse while `busy` is 1 has no effect. The current frame completes with its own result and no further receive follows.
- R11: `dat_release` is 1 for every cycle of a receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a receive (idle only) |
| exp_bytes | input | $clog2(MAX_BYTES+1) | Data bytes expected on acknowledge, clamped to MAX_BYTES |
| sdat_n | input | 1 | Serial data line, active-low |
| sclk | output | 1 | Serial clock to the slave |
| dat_release | output | 1 | High: data line driver must be tri-stated |
| busy | output | 1 | Receive in progress |
| done | output | 1 | One-cycle result strobe |
| resp_id | output | 2 | Responding slave id |
| resp_tag | output | 2 | Response tag |
| rdata | output | 8*MAX_BYTES | Received data, right-aligned |
| status | output | 2 | 0 ok, 1 timeout, 2 check-code error |

## Verification
The bench builds the receiver with MAX_BYTES = 4 and TIMEOUT = 40. The short timeout lets a run reach both the last accepted hunt slot and the expiry case within a few hundred cycles. The 4-byte width exercises the complete 32-bit data field and byte ordering for every byte count from 0 to 4. A slave model driven by `sclk` plays frames with computed check codes through every tag value, plus a frame with one corrupted check bit.

// File: rtl/resp_rx.sv
module resp_rx #(
  parameter int MAX_BYTES = 4,
  parameter int TIMEOUT = 1000,
  parameter logic [3:0] CRC_POLY = 4'h3,
  localparam int DW = 8 * MAX_BYTES,
  localparam int BYW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BYW-1:0] exp_bytes,
  input  logic          sdat_n,
  output logic          sclk,
  output logic          dat_release,
  output logic          busy,
  output logic          done,
  output logic [1:0]    resp_id,
  output logic [1:0]    resp_tag,
  output logic [DW-1:0] rdata,
  output logic [1:0]    status
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int BITW = $clog2(DW + 1);
  localparam int CNTW = (TW > BITW) ? TW : BITW;

  typedef enum logic [2:0] {S_IDLE, S_HUNT, S_HDR, S_DATA, S_CRC} st_t;

  st_t            st;
  logic           ph;
  logic [CNTW-1:0] cnt;
  logic [BITW-1:0] nbits;
  logic [3:0]     hdr, crc;
  logic [BYW-1:0] nb_c;

  wire       bit_in = ~sdat_n;
  wire       samp = (st != S_IDLE) && ph;
  wire [3:0] hdr_nxt = {hdr[2:0], bit_in};
  wire [3:0] crc_nxt = {crc[2:0], 1'b0} ^ ({4{crc[3] ^ bit_in}} & CRC_POLY);

  assign nb_c = (exp_bytes > BYW'(MAX_BYTES)) ? BYW'(MAX_BYTES) : exp_bytes;
  assign busy = (st != S_IDLE);
  assign sclk = !busy || ph;
  assign dat_release = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 1'b0;
      cnt      <= '0;
      nbits    <= '0;
      hdr      <= '0;
      crc      <= '0;
      done     <= 1'b0;
      status   <= 2'd0;
      resp_id  <= 2'd0;
      resp_tag <= 2'd0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st    <= S_HUNT;
          ph    <= 1'b0;
          cnt   <= '0;
          hdr   <= '0;
          crc   <= '0;
          rdata <= '0;
          nbits <= BITW'({nb_c, 3'b000});
        end
      end else begin
        ph <= ~ph;
        if (samp) begin
          case (st)
            S_HUNT: begin
              if (bit_in) begin
                st  <= S_HDR;
                cnt <= '0;
                crc <= crc_nxt;
              end else if (cnt == CNTW'(TIMEOUT - 1)) begin
                st       <= S_IDLE;
                done     <= 1'b1;
                status   <= 2'd1;
                resp_id  <= 2'd0;
                resp_tag <= 2'd0;
                rdata    <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_HDR: begin
              hdr <= hdr_nxt;
              crc <= crc_nxt;
              if (cnt == CNTW'(3)) begin
                cnt <= '0;
                st  <= (hdr_nxt[1:0] == 2'd0 && nbits != '0) ? S_DATA : S_CRC;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_DATA: begin
              rdata <= {rdata[DW-2:0], bit_in};
              crc   <= crc_nxt;
              if (cnt == CNTW'(nbits) - CNTW'(1)) begin
                cnt <= '0;
                st  <= S_CRC;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_CRC: begin
              crc <= crc_nxt;
              if (cnt == CNTW'(3)) begin
                st       <= S_IDLE;
                done     <= 1'b1;
                status   <= (crc_nxt != 4'd0) ? 2'd2 : 2'd0;
                resp_id  <= hdr[3:2];
                resp_tag <= hdr[1:0];
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/resp_rx_chk.sv
module resp_rx_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk,
  input logic          busy,
  input logic          done,
  input logic [1:0]    resp_id,
  input logic [1:0]    resp_tag,
  input logic [DW-1:0] rdata,
  input logic [1:0]    status
);
  a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

  a_r2_first_slot_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sclk);

  a_r2_slot_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> sclk != $past(sclk));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r4_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 2'd1 |-> resp_id == 2'd0 && resp_tag == 2'd0 && rdata == '0);

  a_r6_no_data_unless_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done && resp_tag != 2'd0 |-> rdata == '0);
endmodule

bind resp_rx resp_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .busy(busy), .done(done),
  .resp_id(resp_id), .resp_tag(resp_tag), .rdata(rdata), .status(status)
);

// File: tb/resp_rx_tb_top.sv
`timescale 1ns/1ps
module resp_rx_tb_top;
  localparam int MAXB = 4;
  localparam int TO = 40;
  localparam int DW = 8 * MAXB;

  logic clk = 0, rst_n = 0, start = 0, sdat_n = 1;
  logic [2:0] exp_bytes = '0;
  logic sclk, dat_release, busy, done;
  logic [1:0] resp_id, resp_tag, status;
  logic [DW-1:0] rdata;

  always #5 clk = ~clk;

  resp_rx #(.MAX_BYTES(MAXB), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_bytes(exp_bytes),
    .sdat_n(sdat_n), .sclk(sclk), .dat_release(dat_release), .busy(busy),
    .done(done), .resp_id(resp_id), .resp_tag(resp_tag), .rdata(rdata),
    .status(status)
  );

  typedef struct {
    logic [1:0] st;
    logic [1:0] id;
    logic [1:0] tag;
    logic [DW-1:0] data;
    string req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [63:0] fr;
  int flen = 0, gap = 0, slot = 0;
  bit rel_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] cstep(input logic [3:0] c, input logic b);
    return {c[2:0], 1'b0} ^ ((c[3] ^ b) ? 4'h3 : 4'h0);
  endfunction

  // slave model: one new bit per low phase of sclk
  initial begin
    forever begin
      @(negedge clk);
      if (sclk === 1'b0) begin
        automatic int k;
        k = slot - gap;
        if (slot < gap) sdat_n = 1'b1;
        else if (k < flen) sdat_n = ~fr[flen-1-k];
        else sdat_n = 1'b1;
        slot++;
      end
    end
  end

  // monitor: scoreboard compare on done
  initial begin
    forever begin
      @(negedge clk);
      if (busy && !dat_release) rel_bad = 1;
      if (done) begin
        item_t e;
        check(busy == 1'b0, "R9", "busy at done", busy, 0);
        check(!rel_bad, "R11", "release during receive", rel_bad, 0);
        rel_bad = 0;
        if (q.size() == 0) begin
          check(0, "R9", "unexpected done", 1, 0);
        end else begin
          e = q.pop_front();
          check(status == e.st && resp_id == e.id && resp_tag == e.tag && rdata == e.data,
                e.req, "result {st,id,tag,data}",
                {status, resp_id, resp_tag, rdata}, {e.st, e.id, e.tag, e.data});
        end
      end
    end
  end

  task automatic xfer(input int g, input logic [1:0] id, input logic [1:0] tag,
                      input int eb, input logic [31:0] d, input bit bad, input bit to,
                      input bit extra_start, input string req);
    logic [63:0] f;
    int n;
    logic [3:0] c;
    item_t e;
    f = 0; n = 0; c = 0;
    f = (f << 1) | 64'd1; n++; c = cstep(c, 1'b1);
    for (int i = 1; i >= 0; i--) begin f = (f << 1) | 64'(id[i]); n++; c = cstep(c, id[i]); end
    for (int i = 1; i >= 0; i--) begin f = (f << 1) | 64'(tag[i]); n++; c = cstep(c, tag[i]); end
    if (tag == 2'd0)
      for (int i = eb*8-1; i >= 0; i--) begin f = (f << 1) | 64'(d[i]); n++; c = cstep(c, d[i]); end
    if (bad) c[0] = ~c[0];
    for (int i = 3; i >= 0; i--) begin f = (f << 1) | 64'(c[i]); n++; end
    e.req = req;
    if (to) begin
      e.st = 2'd1; e.id = 0; e.tag = 0; e.data = 0;
    end else begin
      e.st = bad ? 2'd2 : 2'd0; e.id = id; e.tag = tag;
      e.data = (tag == 2'd0 && eb > 0) ? (d & ((eb >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (eb*8)) - 1))) : 0;
    end
    q.push_back(e);
    @(negedge clk);
    fr = f; flen = n; gap = g; slot = 0;
    exp_bytes = 3'(eb);
    start = 1;
    @(negedge clk);
    start = 0;
    check(sclk == 1'b0 && busy, "R2", "first slot low", sclk, 0);
    if (extra_start) begin
      repeat (9) @(negedge clk);
      exp_bytes = 3'd0;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (extra_start) check(busy == 1'b0, "R10", "no receive after ignored start", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sclk && !busy && !done && !dat_release, "R1", "reset idle {sclk,busy,done,rel}",
          {sclk, busy, done, dat_release}, 4'b1000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    xfer(3, 2'd2, 2'd0, 4, 32'hA1B2C3D4, 0, 0, 0, "R7");
    xfer(0, 2'd1, 2'd0, 1, 32'h0000005A, 0, 0, 0, "R6");
    xfer(5, 2'd3, 2'd0, 2, 32'h0000BEEF, 0, 0, 0, "R7");
    xfer(1, 2'd0, 2'd0, 3, 32'h00123456, 0, 0, 0, "R7");
    xfer(2, 2'd1, 2'd0, 0, 32'h0, 0, 0, 0, "R6");
    xfer(2, 2'd3, 2'd1, 4, 32'hFFFF0000, 0, 0, 0, "R6");
    xfer(0, 2'd2, 2'd2, 0, 32'h0, 0, 0, 0, "R5");
    xfer(4, 2'd1, 2'd3, 2, 32'h0, 0, 0, 0, "R5");
    xfer(2, 2'd1, 2'd0, 2, 32'h00001234, 1, 0, 0, "R8");
    xfer(1, 2'd2, 2'd1, 0, 32'h0, 1, 0, 0, "R8");
    xfer(TO-1, 2'd3, 2'd0, 1, 32'h000000C3, 0, 0, 0, "R3");
    xfer(TO, 2'd3, 2'd0, 1, 32'h000000C3, 0, 1, 0, "R4");
    xfer(1000, 2'd0, 2'd0, 0, 32'h0, 0, 1, 0, "R4");
    xfer(2, 2'd2, 2'd0, 4, 32'h89ABCDEF, 0, 0, 1, "R10");
    check(sclk && !busy, "R1", "idle after runs", {sclk, busy}, 2'b10);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule